// File: doc/BRIEF.md
# Sixteen-bit multicycle processor core

The core executes a compact instruction set on a 16-bit datapath with a program counter, an instruction register, eight general-purpose registers and an ALU. A sequencer carries every instruction through fetch, decode and execute states, with one extra state for memory operands. There is no pipelining overlap: one instruction is in flight at a time.

The core is wired to a synchronous single-port RAM through an address, write data, read data and write enable. Read data is taken exactly one clock after the address is presented, so the bus has no ready or acknowledge handshake. An I/O bridge inside the core claims one address for the board. Reading it returns the switch inputs, and writing it loads the hex-display register. A pause instruction shows an 8-bit code on the display and stalls until the operator raises the continue input.

Top module: `mcpu16_core`

## Requirements
- R1: While rst_ni is low and on the first fetch after reset, mem_addr_o is 0x0000, mem_we_o is 0, hex_o is 0x0000 and paused_o is 0. All eight registers read 0 and the condition code is Z.
- R2: The opcode is bits 15:12. ADD is 0x1 and AND is 0x5, each with destination bits 11:9 and first source bits 8:6. When bit 5 is 1 the second operand is bits 4:0 sign-extended; otherwise it is the register in bits 2:0.
- R3: NOT (0x9) writes the bitwise complement of the register in bits 8:6 to the register in bits 11:9.
- R4: ADD, AND, NOT and LDR set exactly one of the flags N, Z, P from the sign and zero state of the value they write. No other instruction changes the flags.
- R5: BR (0x0) takes the branch when its mask (bit 11 = N, bit 10 = Z, bit 9 = P) shares a set bit with the flags. The target is the incremented PC plus bits 8:0 sign-extended. A mask of 000 never branches.
- R6: JMP (0xC) loads the PC from the register in bits 8:6. JSR (0x4) writes the incremented PC into R7. With bit 11 set it jumps to the incremented PC plus bits 10:0 sign-extended; with bit 11 clear it jumps to the register in bits 8:6, read before R7 is written.
- R7: LDR (0x6) and STR (0x7) use as address the register in bits 8:6 plus bits 5:0 sign-extended. STR stores the register in bits 11:9. LDR writes that register with the RAM data sampled one clock after the address, through one added wait state.
- R8: The address 0xFFFF is I/O. LDR from it returns sw_i as sampled in the cycle the address is driven, and STR to it loads hex_o and keeps mem_we_o low.
- R9: PAUSE (0xD) sets hex_o to {8'h00, bits 7:0}. It then holds paused_o high with no fetch and no write until resume_i is seen high at a clock edge, after which execution continues with the next instruction.
- R10: Opcodes other than the nine listed only advance the PC; registers, flags, RAM and hex_o are unchanged.
- R11: mem_we_o is high for exactly one cycle for each STR to a RAM address and is low at all other times.
- R12: Each instruction is read from the PC, and the PC is incremented once in the cycle that latches the instruction register, before decode and execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | RAM address |
| mem_we_o | output | 1 | RAM write enable |
| mem_wdata_o | output | 16 | RAM write data |
| mem_rdata_i | input | 16 | RAM read data, valid one clock after the address |
| sw_i | input | 16 | Board switch inputs |
| resume_i | input | 1 | Operator continue input that ends a pause |
| hex_o | output | 16 | Hex-display register |
| paused_o | output | 1 | High while a pause instruction is holding |

## Verification
A wrong flag, register or PC inside the core is invisible until a store or a control transfer uses it. It shows up as a wrong word or a wrong address in the RAM image a few instructions later, or as a pause code that never appears. Every program therefore ends by storing all eight registers, and the whole RAM image plus hex_o is compared against an instruction-level model computed in the bench. A bad wait-state count or I/O decode shows up within one instruction as a loaded value that is wrong, or as a RAM write to the I/O address. Random straight-line programs with skip branches are mixed with directed loops, subroutine calls, I/O accesses and pause and resume sequences.

// File: rtl/mcpu16_pkg.sv
package mcpu16_pkg;
  localparam int XLEN = 16;
  localparam int NREG = 8;
  localparam int RAW  = $clog2(NREG);

  typedef enum logic [3:0] {
    OP_BR    = 4'h0,
    OP_ADD   = 4'h1,
    OP_JSR   = 4'h4,
    OP_AND   = 4'h5,
    OP_LDR   = 4'h6,
    OP_STR   = 4'h7,
    OP_NOT   = 4'h9,
    OP_JMP   = 4'hC,
    OP_PAUSE = 4'hD
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_IR, ST_DECODE, ST_EXEC, ST_MEM, ST_WB, ST_PAUSE
  } state_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_AND, ALU_NOT, ALU_PASS} alu_op_e;

  function automatic logic [XLEN-1:0] sext5(input logic [4:0] v);
    return {{(XLEN-5){v[4]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] sext6(input logic [5:0] v);
    return {{(XLEN-6){v[5]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] sext9(input logic [8:0] v);
    return {{(XLEN-9){v[8]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] sext11(input logic [10:0] v);
    return {{(XLEN-11){v[10]}}, v};
  endfunction

  // flags ordered {n, z, p}
  function automatic logic [2:0] nzp(input logic [XLEN-1:0] v);
    if (v[XLEN-1]) return 3'b100;
    if (v == '0)   return 3'b010;
    return 3'b001;
  endfunction
endpackage

// File: rtl/mcpu16_regfile.sv
module mcpu16_regfile #(
  parameter int W = 16,
  parameter int N = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o
);
  logic [W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs[g] <= '0;
      else if (we_i && waddr_i == AW'(g))        regs[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];
endmodule

// File: rtl/mcpu16_alu.sv
module mcpu16_alu
  import mcpu16_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_NOT: y_o = ~a_i;
      default: y_o = b_i;
    endcase
  end
endmodule

// File: rtl/mcpu16_iobridge.sv
module mcpu16_iobridge #(
  parameter int          W       = 16,
  parameter logic [W-1:0] IO_ADDR = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] core_addr_i,
  input  logic         core_we_i,
  input  logic [W-1:0] core_wdata_i,
  output logic [W-1:0] core_rdata_o,
  output logic [W-1:0] mem_addr_o,
  output logic         mem_we_o,
  output logic [W-1:0] mem_wdata_o,
  input  logic [W-1:0] mem_rdata_i,
  input  logic [W-1:0] sw_i,
  input  logic         pause_we_i,
  input  logic [W-1:0] pause_val_i,
  output logic [W-1:0] hex_o
);
  logic         io_hit;
  logic         io_rd_q;
  logic [W-1:0] sw_q;
  logic [W-1:0] hex_q;

  assign io_hit      = (core_addr_i == IO_ADDR);
  assign mem_addr_o  = core_addr_i;
  assign mem_wdata_o = core_wdata_i;
  assign mem_we_o    = core_we_i && !io_hit;

  // switch sample aligned with RAM read latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_rd_q <= 1'b0;
      sw_q    <= '0;
    end else begin
      io_rd_q <= io_hit;
      sw_q    <= sw_i;
    end
  end

  assign core_rdata_o = io_rd_q ? sw_q : mem_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      hex_q <= '0;
    else if (pause_we_i)              hex_q <= pause_val_i;
    else if (core_we_i && io_hit)     hex_q <= core_wdata_i;
  end

  assign hex_o = hex_q;
endmodule

// File: rtl/mcpu16_core.sv
module mcpu16_core
  import mcpu16_pkg::*;
#(
  parameter logic [XLEN-1:0] RST_PC  = '0,
  parameter logic [XLEN-1:0] IO_ADDR = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] mem_addr_o,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  input  logic [XLEN-1:0] sw_i,
  input  logic            resume_i,
  output logic [XLEN-1:0] hex_o,
  output logic            paused_o
);
  localparam logic [RAW-1:0] LINK = RAW'(NREG - 1);

  state_e          state_q, state_d;
  logic [XLEN-1:0] pc_q, ir_q, op_a_q, op_b_q, mar_q;
  logic [2:0]      cc_q;
  opcode_e         op;

  logic [XLEN-1:0] core_addr, core_rdata;
  logic            core_we;
  logic            pause_we;

  logic            rf_we;
  logic [RAW-1:0]  rf_waddr, rf_ra_b;
  logic [XLEN-1:0] rf_wdata, rf_a, rf_b;

  alu_op_e         alu_op;
  logic [XLEN-1:0] alu_y;
  logic            br_take;

  assign op = opcode_e'(ir_q[15:12]);

  assign rf_ra_b = (op == OP_STR) ? ir_q[11:9] : ir_q[2:0];

  mcpu16_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (rf_we),
    .waddr_i  (rf_waddr),
    .wdata_i  (rf_wdata),
    .raddr_a_i(ir_q[8:6]),
    .raddr_b_i(rf_ra_b),
    .rdata_a_o(rf_a),
    .rdata_b_o(rf_b)
  );

  always_comb begin
    unique case (op)
      OP_ADD:  alu_op = ALU_ADD;
      OP_AND:  alu_op = ALU_AND;
      OP_NOT:  alu_op = ALU_NOT;
      default: alu_op = ALU_PASS;
    endcase
  end

  mcpu16_alu #(.W(XLEN)) u_alu (
    .op_i(alu_op),
    .a_i (op_a_q),
    .b_i (op_b_q),
    .y_o (alu_y)
  );

  assign core_addr = (state_q == ST_MEM) ? mar_q : pc_q;
  assign core_we   = (state_q == ST_MEM) && (op == OP_STR);
  assign pause_we  = (state_q == ST_EXEC) && (op == OP_PAUSE);

  mcpu16_iobridge #(.W(XLEN), .IO_ADDR(IO_ADDR)) u_io (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .core_addr_i (core_addr),
    .core_we_i   (core_we),
    .core_wdata_i(op_b_q),
    .core_rdata_o(core_rdata),
    .mem_addr_o  (mem_addr_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .sw_i        (sw_i),
    .pause_we_i  (pause_we),
    .pause_val_i ({8'h00, ir_q[7:0]}),
    .hex_o       (hex_o)
  );

  assign br_take = |(ir_q[11:9] & cc_q);

  // register write port
  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = ir_q[11:9];
    rf_wdata = alu_y;
    if (state_q == ST_EXEC) begin
      unique case (op)
        OP_ADD, OP_AND, OP_NOT: rf_we = 1'b1;
        OP_JSR: begin
          rf_we    = 1'b1;
          rf_waddr = LINK;
          rf_wdata = pc_q;
        end
        default: ;
      endcase
    end else if (state_q == ST_WB) begin
      rf_we    = 1'b1;
      rf_wdata = core_rdata;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH:  state_d = ST_IR;
      ST_IR:     state_d = ST_DECODE;
      ST_DECODE: state_d = ST_EXEC;
      ST_EXEC: begin
        unique case (op)
          OP_LDR, OP_STR: state_d = ST_MEM;
          OP_PAUSE:       state_d = ST_PAUSE;
          default:        state_d = ST_FETCH;
        endcase
      end
      ST_MEM:    state_d = (op == OP_STR) ? ST_FETCH : ST_WB;
      ST_WB:     state_d = ST_FETCH;
      ST_PAUSE:  state_d = resume_i ? ST_FETCH : ST_PAUSE;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      pc_q    <= RST_PC;
      ir_q    <= '0;
      op_a_q  <= '0;
      op_b_q  <= '0;
      mar_q   <= '0;
      cc_q    <= 3'b010;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_IR: begin
          ir_q <= core_rdata;
          pc_q <= pc_q + 1'b1;
        end
        ST_DECODE: begin
          op_a_q <= rf_a;
          op_b_q <= ((op == OP_ADD || op == OP_AND) && ir_q[5]) ? sext5(ir_q[4:0]) : rf_b;
        end
        ST_EXEC: begin
          unique case (op)
            OP_ADD, OP_AND, OP_NOT: cc_q <= nzp(alu_y);
            OP_BR:  if (br_take) pc_q <= pc_q + sext9(ir_q[8:0]);
            OP_JMP: pc_q <= op_a_q;
            OP_JSR: pc_q <= ir_q[11] ? pc_q + sext11(ir_q[10:0]) : op_a_q;
            OP_LDR, OP_STR: mar_q <= op_a_q + sext6(ir_q[5:0]);
            default: ;
          endcase
        end
        ST_WB:   cc_q <= nzp(core_rdata);
        default: ;
      endcase
    end
  end

  assign paused_o = (state_q == ST_PAUSE);
endmodule

// File: rtl/mcpu16_core_chk.sv
module mcpu16_core_chk
  import mcpu16_pkg::*;
#(
  parameter logic [XLEN-1:0] IO_ADDR = '1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] mem_addr_o,
  input logic            mem_we_o,
  input logic [XLEN-1:0] hex_o,
  input logic            paused_o,
  input logic            resume_i,
  input state_e          state_q,
  input logic [XLEN-1:0] pc_q,
  input logic [XLEN-1:0] core_addr,
  input logic            core_we
);
  assert_io_no_ram_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o != IO_ADDR);

  assert_hex_only_on_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_EXEC && !(core_we && core_addr == IO_ADDR)) |=> $stable(hex_o));

  assert_pause_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paused_o && !resume_i) |=> paused_o);

  assert_pause_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_o |-> (!mem_we_o && $stable(pc_q)));

  assert_we_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  assert_load_wait_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MEM && !core_we) |=> state_q == ST_WB);

  assert_pc_step_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IR |=> (pc_q == $past(pc_q) + 1'b1 && state_q == ST_DECODE));
endmodule

bind mcpu16_core mcpu16_core_chk #(.IO_ADDR(IO_ADDR)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mem_addr_o(mem_addr_o),
  .mem_we_o  (mem_we_o),
  .hex_o     (hex_o),
  .paused_o  (paused_o),
  .resume_i  (resume_i),
  .state_q   (state_q),
  .pc_q      (pc_q),
  .core_addr (core_addr),
  .core_we   (core_we)
);

// File: tb/mcpu16_core_tb.sv
module mcpu16_core_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        resume;
  logic [15:0] sw;
  logic [15:0] addr, wdata, rdata, hex;
  logic        we, paused;
  logic        load;

  logic [15:0] mem    [256];
  logic [15:0] img    [256];
  logic [15:0] iss_m  [256];
  logic [15:0] iss_r  [8];
  logic [2:0]  iss_cc;
  logic [15:0] iss_hex;

  int n_chk = 0;
  int n_fail = 0;
  int pw = 0;

  always #5 clk = ~clk;

  mcpu16_core u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .mem_addr_o (addr),
    .mem_we_o   (we),
    .mem_wdata_o(wdata),
    .mem_rdata_i(rdata),
    .sw_i       (sw),
    .resume_i   (resume),
    .hex_o      (hex),
    .paused_o   (paused)
  );

  // synchronous RAM model, 256 words aliased over the address space
  always @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < 256; i++) mem[i] <= img[i];
    end else if (we) begin
      mem[addr[7:0]] <= wdata;
    end
    rdata <= mem[addr[7:0]];
  end

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // encoders
  function automatic logic [15:0] e_add (int d, int a, int b);   return {4'h1, d[2:0], a[2:0], 3'b000, b[2:0]}; endfunction
  function automatic logic [15:0] e_addi(int d, int a, int imm); return {4'h1, d[2:0], a[2:0], 1'b1, imm[4:0]}; endfunction
  function automatic logic [15:0] e_and (int d, int a, int b);   return {4'h5, d[2:0], a[2:0], 3'b000, b[2:0]}; endfunction
  function automatic logic [15:0] e_andi(int d, int a, int imm); return {4'h5, d[2:0], a[2:0], 1'b1, imm[4:0]}; endfunction
  function automatic logic [15:0] e_not (int d, int a);          return {4'h9, d[2:0], a[2:0], 6'h3F}; endfunction
  function automatic logic [15:0] e_br  (int m, int off);        return {4'h0, m[2:0], off[8:0]}; endfunction
  function automatic logic [15:0] e_jmp (int b);                 return {4'hC, 3'b000, b[2:0], 6'h00}; endfunction
  function automatic logic [15:0] e_jsr (int off);               return {4'h4, 1'b1, off[10:0]}; endfunction
  function automatic logic [15:0] e_jsrr(int b);                 return {4'h4, 3'b000, b[2:0], 6'h00}; endfunction
  function automatic logic [15:0] e_ldr (int d, int b, int off); return {4'h6, d[2:0], b[2:0], off[5:0]}; endfunction
  function automatic logic [15:0] e_str (int s, int b, int off); return {4'h7, s[2:0], b[2:0], off[5:0]}; endfunction
  function automatic logic [15:0] e_pause(int v);                return {4'hD, 4'h0, v[7:0]}; endfunction

  function automatic logic [15:0] sx(input logic [15:0] v, input int w);
    logic [15:0] m;
    m = 16'hFFFF << w;
    return v[w-1] ? (v | m) : (v & ~m);
  endfunction

  function automatic logic [2:0] flags(input logic [15:0] v);
    if (v[15]) return 3'b100;
    if (v == 16'h0) return 3'b010;
    return 3'b001;
  endfunction

  task automatic emit(input logic [15:0] w);
    img[pw[7:0]] = w;
    pw++;
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 16'h0;
    pw = 0;
  endtask

  // R6 stays zero: registers land at 0xFFFE down to 0xFFF7
  task automatic dump_pause(input int code);
    for (int i = 0; i < 8; i++) emit(e_str(i, 6, -(i + 2)));
    emit(e_pause(code));
  endtask

  // instruction-level reference model
  task automatic iss_run(output bit hit);
    logic [15:0] pc, ir, a, b, v;
    for (int i = 0; i < 8; i++) iss_r[i] = 16'h0;
    pc = 16'h0; iss_cc = 3'b010; iss_hex = 16'h0; hit = 1'b0;
    for (int s = 0; s < 4000 && !hit; s++) begin
      ir = iss_m[pc[7:0]];
      pc = pc + 16'h1;
      case (ir[15:12])
        4'h1, 4'h5: begin
          b = ir[5] ? sx(ir, 5) : iss_r[ir[2:0]];
          a = iss_r[ir[8:6]];
          v = (ir[15:12] == 4'h1) ? a + b : a & b;
          iss_r[ir[11:9]] = v; iss_cc = flags(v);
        end
        4'h9: begin v = ~iss_r[ir[8:6]]; iss_r[ir[11:9]] = v; iss_cc = flags(v); end
        4'h0: if (|(ir[11:9] & iss_cc)) pc = pc + sx(ir, 9);
        4'hC: pc = iss_r[ir[8:6]];
        4'h4: begin
          a = ir[11] ? pc + sx(ir, 11) : iss_r[ir[8:6]];
          iss_r[7] = pc; pc = a;
        end
        4'h6: begin
          a = iss_r[ir[8:6]] + sx(ir, 6);
          v = (a == 16'hFFFF) ? sw : iss_m[a[7:0]];
          iss_r[ir[11:9]] = v; iss_cc = flags(v);
        end
        4'h7: begin
          a = iss_r[ir[8:6]] + sx(ir, 6);
          if (a == 16'hFFFF) iss_hex = iss_r[ir[11:9]];
          else iss_m[a[7:0]] = iss_r[ir[11:9]];
        end
        4'hD: begin iss_hex = {8'h00, ir[7:0]}; hit = 1'b1; end
        default: ;
      endcase
    end
  endtask

  task automatic load_and_reset();
    rst_n = 1'b0; resume = 1'b0; load = 1'b1;
    @(negedge clk); @(negedge clk);
    load = 1'b0;
  endtask

  task automatic run_prog(input string tag, input bit expect_pause);
    bit hit;
    int cyc, bad, first;
    load_and_reset();
    for (int i = 0; i < 256; i++) iss_m[i] = img[i];
    iss_run(hit);
    rst_n = 1'b1;
    cyc = 0;
    while (!paused && cyc < 6000) begin @(negedge clk); cyc++; end
    if (!expect_pause) while (cyc < 600) begin @(negedge clk); cyc++; end
    check(paused == expect_pause, {tag, " pause state"}, {15'h0, paused}, {15'h0, expect_pause});
    bad = 0; first = 0;
    for (int i = 0; i < 256; i++)
      if (mem[i] !== iss_m[i]) begin if (bad == 0) first = i; bad++; end
    check(bad == 0, {tag, " ram image"}, mem[first], iss_m[first]);
    check(hex === iss_hex, {tag, " hex"}, hex, iss_hex);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired act=%h exp=%h", 16'h0, 16'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0101));
    rst_n = 1'b0; resume = 1'b0; load = 1'b0; sw = 16'h0;
    clear_img();

    // R1 reset state and first fetch
    emit(e_addi(0, 0, 1));
    dump_pause(8'h11);
    load_and_reset();
    check(addr == 16'h0, "R1 reset addr", addr, 16'h0);
    check(we == 1'b0 && paused == 1'b0, "R1 reset we/paused", {14'h0, we, paused}, 16'h0);
    check(hex == 16'h0, "R1 reset hex", hex, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(addr == 16'h0, "R1 first fetch addr", addr, 16'h0);
    for (int i = 0; i < 8; i++) iss_m[i] = 16'h0;
    run_prog("R1 regs zero after reset", 1'b1);

    // R2 R3 R10 operand modes, complement, unlisted opcodes
    clear_img();
    emit(e_addi(0, 0, 7));
    emit(e_addi(1, 0, -3));
    emit(16'hF123);
    emit(e_add(2, 0, 1));
    emit(e_and(3, 2, 0));
    emit(16'h8FFF);
    emit(e_andi(4, 2, -6));
    emit(e_not(5, 4));
    emit(16'hB000);
    dump_pause(8'h5A);
    run_prog("R2 R3 R10 alu", 1'b1);

    // R4 R5 flags and branch masks
    clear_img();
    emit(e_addi(0, 0, -1));
    emit(e_br(3'b100, 1));
    emit(e_addi(1, 1, 1));
    emit(e_andi(0, 0, 0));
    emit(e_br(3'b010, 1));
    emit(e_addi(1, 1, 2));
    emit(e_br(3'b101, 1));
    emit(e_addi(1, 1, 4));
    emit(e_br(3'b000, 1));
    emit(e_addi(1, 1, 8));
    emit(e_not(2, 0));
    emit(e_br(3'b011, 1));
    emit(e_addi(3, 3, 5));
    dump_pause(8'h44);
    run_prog("R4 R5 flags", 1'b1);

    // R5 backward loop
    clear_img();
    emit(e_addi(0, 0, 5));
    emit(e_add(1, 1, 0));
    emit(e_addi(0, 0, -1));
    emit(e_br(3'b001, -3));
    dump_pause(8'h55);
    run_prog("R5 loop", 1'b1);

    // R6 calls and returns
    clear_img();
    emit(e_jsr(2));          // 0 -> 3
    emit(e_addi(1, 1, 1));   // 1
    emit(e_br(3'b111, 3));   // 2 -> 6
    emit(e_addi(2, 2, 9));   // 3
    emit(e_add(3, 7, 7));    // 4
    emit(e_jmp(7));          // 5 -> 1
    emit(e_andi(0, 0, 0));   // 6
    emit(e_addi(0, 0, 12));  // 7
    emit(e_jsrr(0));         // 8 -> 12
    emit(e_br(3'b111, 4));   // 9 -> 14
    emit(16'h0000);          // 10
    emit(16'h0000);          // 11
    emit(e_addi(4, 4, 1));   // 12
    emit(e_jmp(7));          // 13 -> 9
    dump_pause(8'h66);
    run_prog("R6 jsr jmp", 1'b1);

    // R7 R8 loads, stores, io; ends in a self loop
    clear_img();
    sw = 16'hC3A5;
    img[8'hE0] = 16'h1234;
    img[8'hEC] = 16'h0F0F;
    img[8'hE5] = 16'h0000;
    img[8'hFF] = 16'hBEEF;
    pw = 0;
    emit(e_ldr(0, 6, -32));
    emit(e_ldr(1, 6, -20));
    emit(e_add(2, 0, 1));
    emit(e_str(2, 6, -16));
    emit(e_not(3, 6));
    emit(e_ldr(4, 3, 0));
    emit(e_str(4, 6, -15));
    emit(e_str(2, 3, 0));
    emit(e_ldr(5, 6, -27));
    emit(e_br(3'b010, 1));
    emit(e_addi(5, 5, 1));
    emit(e_str(5, 6, -14));
    emit(e_br(3'b111, -1));
    run_prog("R7 R8 R11 load store io", 1'b0);
    check(mem[8'hFF] == 16'hBEEF, "R8 R11 no ram write at io", mem[8'hFF], 16'hBEEF);
    check(hex == 16'h2143, "R8 hex from store", hex, 16'h2143);
    check(mem[8'hF1] == 16'hC3A5, "R8 switch read", mem[8'hF1], 16'hC3A5);

    // R9 pause and resume
    clear_img();
    emit(e_addi(0, 0, 3));
    emit(e_pause(8'hA5));
    emit(e_addi(0, 0, 1));
    emit(e_str(0, 6, -2));
    emit(e_pause(8'h3C));
    load_and_reset();
    rst_n = 1'b1;
    for (int c = 0; c < 200 && !paused; c++) @(negedge clk);
    check(hex == 16'h00A5, "R9 pause code", hex, 16'h00A5);
    repeat (30) @(negedge clk);
    check(paused == 1'b1, "R9 holds", {15'h0, paused}, 16'h1);
    check(mem[8'hFE] == 16'h0, "R9 no progress", mem[8'hFE], 16'h0);
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
    check(paused == 1'b0, "R9 released", {15'h0, paused}, 16'h0);
    for (int c = 0; c < 200 && !paused; c++) @(negedge clk);
    check(hex == 16'h003C, "R9 second code", hex, 16'h003C);
    check(mem[8'hFE] == 16'h0004, "R9 continues", mem[8'hFE], 16'h0004);

    // R2 R3 R4 R5 R7 random programs
    for (int t = 0; t < 20; t++) begin
      clear_img();
      sw = 16'($urandom);
      for (int i = 8'hE0; i <= 8'hF6; i++) img[i] = 16'($urandom);
      for (int k = 0; k < 40; k++) begin
        int d, a, b, imm, off;
        d = $urandom_range(0, 5);
        a = $urandom_range(0, 7);
        b = $urandom_range(0, 7);
        imm = int'($urandom_range(0, 31)) - 16;
        off = -32 + int'($urandom_range(0, 22));
        case ($urandom_range(0, 7))
          0: emit(e_add(d, a, b));
          1: emit(e_addi(d, a, imm));
          2: emit(e_and(d, a, b));
          3: emit(e_andi(d, a, imm));
          4: emit(e_not(d, a));
          5: emit(e_ldr(d, 6, off));
          6: emit(e_str(a, 6, off));
          default: emit(e_br(int'($urandom_range(0, 7)), 1));
        endcase
      end
      dump_pause(t);
      run_prog("R2 R3 R4 R5 R7 random", 1'b1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule